// File: doc/BRIEF.md
# Hotplug Interrupt Locator Aggregator

This block collects the pending events of a set of hot-plug slots, together with a command-completion flag, into one locator word, and turns that word into a single interrupt request. Each slot owns an event latch, set by hardware event inputs and cleared by software writing ones, and a mask that software programs freely. A global control register carries the interrupt disables and the command-completion flag.

The locator is rebuilt every cycle from the register contents. Bit 0 stands for command completion; bit s+1 stands for slot s. When any locator bit is set and the global interrupt disable is clear, the interrupt level is high. In plain mode that level drives the interrupt pin; in message mode the pin stays low and a one-cycle message pulse is issued each time the level changes.

Top module: `hp_irq_locator`

## Requirements
- R1: After reset every slot latch reads 0, every slot mask reads 0x7F, control bits [3:0] read 1111, the command-detected flag reads 0, and locator, interrupt and message outputs are 0.
- R2: Event input bit 5*s+k sets latch bit k of slot s on the next clock edge (k: 0 presence, 1 isolated fault, 2 button, 3 MRL, 4 connected fault); a slot register at address s+1 reads its latch in data bits [4:0].
- R3: A write to slot address s+1 clears each latch bit whose data bit in [4:0] is 1 and leaves bits written 0 unchanged; an event setting a bit in the same cycle as its clear leaves the bit set.
- R4: A write to slot address s+1 loads all seven mask bits from data [14:8]; mask bits 5 and 6 never affect the locator.
- R5: Locator bit s+1 is 1 exactly when the slot's latch AND NOT mask[4:0] is nonzero, visible in the cycle after the register change.
- R6: Command done sets the command-detected flag (address 0, bit 16), which is cleared by writing 1 to bit 16, set winning over clear; locator bit 0 is 1 exactly when the flag is set and control bit 2 is 0.
- R7: The interrupt level is 1 when the locator is nonzero and control bit 0 is 0; the interrupt pin follows that level while message mode is off and is 0 while it is on.
- R8: The last level is recorded on every clock edge in either mode, starting at 0; with message mode on, the message output is 1 for exactly the cycles in which the level differs from the recorded one.
- R9: Writes to addresses above the last slot change nothing, and control register bits other than [3:0] and 16 read 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | NUM_SLOTS*5 | Per-slot event set pulses, slot s at bits [5s+4:5s] |
| cmd_done_i | input | 1 | Command completion pulse |
| msg_en_i | input | 1 | Message signalling mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address: 0 control, s+1 slot s |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| locator_o | output | NUM_SLOTS+1 | Locator word |
| irq_o | output | 1 | Level interrupt pin |
| msg_o | output | 1 | Message pulse |

## Verification
A latch bit stuck or lost shows at once on the slot's read data and, when unmasked, on the matching locator bit in the same cycle. A wrong set-versus-clear priority shows only in cycles where an event and a clearing write coincide, so those collisions are driven on purpose. A stale recorded level shows as a missing or doubled message pulse one cycle after the level moves, which is why message pulses are sampled in the very cycle after the causing edge and again one cycle later.

// File: rtl/hp_irq_locator_pkg.sv
package hp_irq_locator_pkg;
  localparam int EVT_W      = 5;
  localparam int MASK_W     = 7;
  localparam int CTRL_W     = 4;
  localparam int DATA_W     = 32;
  localparam int MASK_LSB   = 8;
  localparam int INT_DIS    = 0;
  localparam int CMD_DIS    = 2;
  localparam int CMD_DET    = 16;
endpackage

// File: rtl/hp_slot_reg.sv
module hp_slot_reg
  import hp_irq_locator_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [EVT_W-1:0]     evt_i,
  output logic [EVT_W-1:0]     latch_o,
  output logic [MASK_W-1:0]    mask_o,
  output logic                 pend_o
);
  logic [EVT_W-1:0] clr;

  assign clr = wr_i ? wr_data_i[EVT_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      mask_o  <= '1;
    end else begin
      // new event beats a same-cycle clear
      latch_o <= (latch_o & ~clr) | evt_i;
      if (wr_i) mask_o <= wr_data_i[MASK_LSB +: MASK_W];
    end
  end

  // upper mask bits gate only error reporting, not the locator
  assign pend_o = |(latch_o & ~mask_o[EVT_W-1:0]);
endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
  import hp_irq_locator_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 cmd_done_i,
  output logic [CTRL_W-1:0]    dis_o,
  output logic                 cmd_det_o,
  output logic                 cmd_pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_o     <= '1;
      cmd_det_o <= 1'b0;
    end else begin
      if (wr_i) dis_o <= wr_data_i[CTRL_W-1:0];
      cmd_det_o <= (cmd_det_o & ~(wr_i & wr_data_i[CMD_DET])) | cmd_done_i;
    end
  end

  assign cmd_pend_o = cmd_det_o & ~dis_o[CMD_DIS];
endmodule

// File: rtl/hp_irq_out.sv
module hp_irq_out #(
  parameter int LOC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOC_W-1:0] loc_i,
  input  logic             int_dis_i,
  input  logic             msg_en_i,
  output logic             level_o,
  output logic             irq_o,
  output logic             msg_o
);
  logic last_q;

  assign level_o = (|loc_i) & ~int_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= level_o;
  end

  assign irq_o = level_o & ~msg_en_i;
  assign msg_o = msg_en_i & (level_o ^ last_q);
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
  import hp_irq_locator_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int LOC_W    = NUM_SLOTS + 1,
  localparam int AW       = $clog2(NUM_SLOTS + 1),
  localparam int EVT_TOT  = NUM_SLOTS * EVT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [EVT_TOT-1:0]  evt_set_i,
  input  logic                cmd_done_i,
  input  logic                msg_en_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [LOC_W-1:0]    locator_o,
  output logic                irq_o,
  output logic                msg_o
);
  logic [CTRL_W-1:0]          dis;
  logic                       cmd_det;
  logic                       cmd_pend;
  logic                       irq_level;
  logic [EVT_TOT-1:0]         latch_flat;
  logic [EVT_W-1:0]           latch [NUM_SLOTS];
  logic [MASK_W-1:0]          mask  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]       slot_pend;

  hp_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i && wr_addr_i == '0),
    .wr_data_i  (wr_data_i),
    .cmd_done_i (cmd_done_i),
    .dis_o      (dis),
    .cmd_det_o  (cmd_det),
    .cmd_pend_o (cmd_pend)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hp_slot_reg u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_en_i && wr_addr_i == AW'(s + 1)),
      .wr_data_i (wr_data_i),
      .evt_i     (evt_set_i[s*EVT_W +: EVT_W]),
      .latch_o   (latch[s]),
      .mask_o    (mask[s]),
      .pend_o    (slot_pend[s])
    );
    assign latch_flat[s*EVT_W +: EVT_W] = latch[s];
  end

  assign locator_o = {slot_pend, cmd_pend};

  hp_irq_out #(.LOC_W(LOC_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .loc_i     (locator_o),
    .int_dis_i (dis[INT_DIS]),
    .msg_en_i  (msg_en_i),
    .level_o   (irq_level),
    .irq_o     (irq_o),
    .msg_o     (msg_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == '0) begin
      rd_data_o[CTRL_W-1:0] = dis;
      rd_data_o[CMD_DET]    = cmd_det;
    end
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_addr_i == AW'(s + 1)) begin
        rd_data_o[EVT_W-1:0]            = latch[s];
        rd_data_o[MASK_LSB +: MASK_W]   = mask[s];
      end
    end
  end
endmodule

// File: rtl/hp_irq_locator_chk.sv
module hp_irq_locator_chk #(
  parameter int NUM_SLOTS = 8,
  localparam int LOC_W    = NUM_SLOTS + 1,
  localparam int EVT_TOT  = NUM_SLOTS * 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [EVT_TOT-1:0] evt_set_i,
  input logic               cmd_done_i,
  input logic               msg_en_i,
  input logic [EVT_TOT-1:0] latch_flat,
  input logic               cmd_det,
  input logic               irq_level,
  input logic [LOC_W-1:0]   locator_o,
  input logic               irq_o,
  input logic               msg_o
);
  // R2
  evt_sets_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_set_i != '0) |=> ((latch_flat & $past(evt_set_i)) == $past(evt_set_i)));

  // R6
  cmd_done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> cmd_det);

  // R6
  cmd_loc_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locator_o[0] |-> cmd_det);

  // R7
  irq_pin_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!msg_en_i && locator_o != '0));

  // R8
  msg_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_en_i && irq_level != $past(irq_level)) |-> msg_o);

  // R8
  msg_mode_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_o |-> msg_en_i);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_loc
    // R5
    slot_loc_needs_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locator_o[s+1] |-> (latch_flat[s*5 +: 5] != '0));
  end
endmodule

bind hp_irq_locator hp_irq_locator_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_set_i  (evt_set_i),
  .cmd_done_i (cmd_done_i),
  .msg_en_i   (msg_en_i),
  .latch_flat (latch_flat),
  .cmd_det    (cmd_det),
  .irq_level  (irq_level),
  .locator_o  (locator_o),
  .irq_o      (irq_o),
  .msg_o      (msg_o)
);

// File: tb/tb_hp_irq_locator.sv
`timescale 1ns/1ps
module tb_hp_irq_locator;
  localparam int NS = 8;
  localparam int AW = $clog2(NS + 1);
  localparam int ET = NS * 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [ET-1:0] evt_set_i = '0;
  logic cmd_done_i = 1'b0;
  logic msg_en_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [NS:0] locator_o;
  logic irq_o, msg_o;

  always #4 clk_i = ~clk_i;

  hp_irq_locator #(.NUM_SLOTS(NS)) dut (.*);

  typedef struct {
    logic [31:0] rd;
    logic [NS:0] loc;
    logic        irq;
    logic        msg;
    string       tag;
  } exp_t;

  exp_t sb[$];
  event smp_ev;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [4:0] m_latch [NS];
  logic [6:0] m_mask  [NS];
  logic [3:0] m_ctrl;
  logic       m_cmd;
  logic       m_last;

  function automatic logic [NS:0] m_loc();
    logic [NS:0] l;
    l[0] = m_cmd & ~m_ctrl[2];
    for (int s = 0; s < NS; s++) l[s+1] = |(m_latch[s] & ~m_mask[s][4:0]);
    return l;
  endfunction

  function automatic logic m_level();
    return (|m_loc()) & ~m_ctrl[0];
  endfunction

  function automatic logic [31:0] m_rd(input int a);
    logic [31:0] d = '0;
    if (a == 0) begin
      d[3:0] = m_ctrl;
      d[16]  = m_cmd;
    end else if (a <= NS) begin
      d[4:0]  = m_latch[a-1];
      d[14:8] = m_mask[a-1];
    end
    return d;
  endfunction

  task automatic cycle(input bit we, input int addr, input logic [31:0] data,
                       input logic [ET-1:0] evt, input bit cd);
    logic nl;
    wr_en_i = we; wr_addr_i = AW'(addr); wr_data_i = data;
    evt_set_i = evt; cmd_done_i = cd;
    nl = m_level();
    if (we) begin
      if (addr == 0) begin
        m_ctrl = data[3:0];
        if (data[16]) m_cmd = 1'b0;
      end else if (addr <= NS) begin
        m_latch[addr-1] = m_latch[addr-1] & ~data[4:0];
        m_mask[addr-1]  = data[14:8];
      end
    end
    for (int s = 0; s < NS; s++) m_latch[s] = m_latch[s] | evt[s*5 +: 5];
    if (cd) m_cmd = 1'b1;
    m_last = nl;
    @(posedge clk_i); #1;
    wr_en_i = 0; evt_set_i = '0; cmd_done_i = 0;
  endtask

  // driver: at most two per cycle, all before the next edge
  task automatic check(input int addr, input string tag);
    exp_t e;
    rd_addr_i = AW'(addr);
    e.rd  = m_rd(addr);
    e.loc = m_loc();
    e.irq = m_level() & ~msg_en_i;
    e.msg = msg_en_i & (m_level() ^ m_last);
    e.tag = tag;
    #1;
    sb.push_back(e);
    -> smp_ev;
    #1;
  endtask

  // monitor
  initial forever begin
    exp_t e;
    @(smp_ev);
    #1;
    e = sb.pop_front();
    n_chk++;
    if (rd_data_o !== e.rd || locator_o !== e.loc || irq_o !== e.irq || msg_o !== e.msg) begin
      n_bad++;
      $display("FAIL %s rd=%h/%h loc=%h/%h irq=%b/%b msg=%b/%b", e.tag,
               rd_data_o, e.rd, locator_o, e.loc, irq_o, e.irq, msg_o, e.msg);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_latch[s] = '0; m_mask[s] = '1; end
    m_ctrl = 4'hF; m_cmd = 0; m_last = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    check(0, "R1");
    check(1, "R1");

    cycle(0, 0, 0, ET'(40'h5) << 10, 0);   // slot 2 presence + button
    check(3, "R2");
    cycle(1, 3, 32'h7B00, '0, 0);          // unmask button
    check(3, "R5");
    cycle(1, 0, 32'hA, '0, 0);             // enable interrupt and command interrupt
    check(0, "R7");
    cycle(1, 3, 32'h1F00, '0, 0);          // only upper mask bits cleared
    check(3, "R4");
    cycle(1, 3, 32'h1F04, '0, 0);          // clear button only
    check(3, "R3");
    cycle(1, 3, 32'h1F01, ET'(40'h1) << 10, 0); // set and clear collide
    check(3, "R3");
    cycle(1, 3, 32'h7F1F, '0, 0);
    check(3, "R3");

    cycle(0, 0, 0, '0, 1);
    check(0, "R6");
    cycle(1, 0, 32'h1000A, '0, 1);         // clear vs new completion
    check(0, "R6");
    cycle(1, 0, 32'h1000A, '0, 0);
    check(0, "R6");

    msg_en_i = 1'b1;
    cycle(0, 0, 0, '0, 1);
    check(0, "R8");
    cycle(0, 0, 0, '0, 0);
    check(0, "R8");
    cycle(1, 0, 32'h1000A, '0, 0);
    check(0, "R8");
    cycle(0, 0, 0, '0, 0);
    check(0, "R8");

    msg_en_i = 1'b0;
    cycle(1, 9, 32'hFFFF_FFFF, '0, 0);
    check(3, "R9");
    check(0, "R9");
    cycle(1, 0, 32'hFFFE_FFF0, '0, 0);
    check(0, "R9");

    cycle(1, 8, 32'h0, ET'(1) << 39, 0);   // last slot, connected fault
    check(8, "R5");
    cycle(1, 1, 32'h6000, ET'(1), 0);      // first slot, serr-only mask bits
    check(1, "R4");
    cycle(1, 0, 32'h4, '0, 1);             // command interrupt disabled
    check(0, "R6");
    check(8, "R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule